// File: doc/BRIEF.md
# Up/Down Capture-Reload Timer

A 16-bit timer/counter with a companion 16-bit register that serves as the reload value or as the capture target, depending on the mode. It advances on one of three step sources: a one-cycle internal timer tick, a falling edge on an event pin, or a half-rate oscillator tick used for baud generation. A trigger pin is sampled on each internal timer tick. A falling edge on it, once qualified, reloads the counter or captures the count.

Three modes exist. Reload mode counts up or down and refills the counter from the companion register. Capture mode counts up freely and latches the count on a trigger edge. Baud mode counts the half-rate tick and emits a single-cycle baud strobe each time it wraps. Software loads both registers through a write port and reads them through a combinational read port. Software can also overwrite the two sticky flags, overflow and external trigger. The registers and flags are plain control pins, with no stream handshake, so the port has no back-pressure.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the counter, the reload register, both flags and the baud strobe are all zero.
- R2: In reload mode counting up, each step adds one. A step taken at FFFFh loads the reload register value instead and sets the overflow flag.
- R3: In reload mode with `down_i` high, each step subtracts one. A step taken while the count equals the reload value loads FFFFh and sets the overflow flag.
- R4: In reload mode, a qualified trigger edge loads the counter from the reload register and sets the external flag. It wins over a step in the same cycle and sets no overflow.
- R5: In capture mode the counter only counts up and wraps from FFFFh to 0000h, setting the overflow flag. A qualified trigger edge copies the current count into the reload register, sets the external flag and leaves the count unchanged.
- R6: Baud mode is active when either `tx_clk_sel_i` or `rx_clk_sel_i` is high, and it overrides capture mode. The counter then steps only on `half_tick_i`. A step at FFFFh reloads the counter and raises `baud_tick_o` for one cycle in the following clock cycle. The overflow flag is not set.
- R7: Outside baud mode with `evt_src_i` high, steps come only from 1-to-0 transitions of `evt_i`, which is sampled every clock; `tick_i` is then ignored. With `evt_src_i` low, steps come from `tick_i`. With `run_i` low, no step occurs.
- R8: `trig_i` is sampled only in cycles with `tick_i` high. An edge is a 1 sample followed by a 0 sample, and it is qualified only while `trig_en_i` is high. A level change between ticks is not seen, and an unqualified edge changes nothing.
- R9: A register write (`reg_sel_i` 0 = counter, 1 = reload register) wins over any hardware update to that register in the same cycle. A flag write (`flag_wdata_i` bit 0 = overflow, bit 1 = external) wins over a hardware set in the same cycle.
- R10: `rd_data_o` shows the counter when `rd_sel_i` is 0 and the reload register when it is 1, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal timer tick, one cycle wide |
| half_tick_i | input | 1 | Half-oscillator-rate tick for baud mode |
| evt_i | input | 1 | External event pin |
| trig_i | input | 1 | External trigger pin |
| run_i | input | 1 | Count enable |
| evt_src_i | input | 1 | 1 = count event-pin edges |
| trig_en_i | input | 1 | Qualifies trigger edges |
| down_i | input | 1 | Count down in reload mode |
| cap_mode_i | input | 1 | Select capture mode |
| tx_clk_sel_i | input | 1 | Baud mode select (transmit) |
| rx_clk_sel_i | input | 1 | Baud mode select (receive) |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 counter, 1 reload |
| reg_wdata_i | input | 16 | Register write data |
| rd_sel_i | input | 1 | Read select: 0 counter, 1 reload |
| rd_data_o | output | 16 | Read data |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag write data: bit 0 overflow, bit 1 external |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky external trigger flag |
| baud_tick_o | output | 1 | Baud strobe, one cycle per wrap |

## Verification
The hardest cases to reach are the ones where two sources want the same register in one cycle. These are a trigger edge against a step, a software flag write against an overflow, and a software count write against a step. To create them, the bench drives the strobe and the tick on the same falling clock edge. It also preloads the counter one step short of its wrap point, so the collision lands on a known edge. Edges that must not be recognised are set up by toggling the trigger pin only between ticks. A further case is the down-count underflow, which needs the count to land exactly on the reload value first.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2
  } tmr_mode_e;

  localparam logic SEL_COUNT  = 1'b0;
  localparam logic SEL_RELOAD = 1'b1;
  localparam int   FLAG_OVF   = 0;
  localparam int   FLAG_EXT   = 1;
endpackage

// File: rtl/tmr_edge_sampler.sv
module tmr_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic evt_i,
  input  logic trig_i,
  input  logic trig_en_i,
  output logic evt_fall_o,
  output logic trig_fire_o
);
  logic evt_q;
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      evt_q <= evt_i;
      if (tick_i) trig_q <= trig_i;
    end
  end

  assign evt_fall_o  = evt_q & ~evt_i;
  assign trig_fire_o = tick_i & trig_en_i & trig_q & ~trig_i;

  // R8
  trig_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(trig_q));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_i,
  input  logic             down_i,
  input  logic             step_i,
  input  logic             trig_fire_i,
  input  logic             wr_cnt_i,
  input  logic             wr_rld_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] rld_o,
  output logic             ovf_set_o,
  output logic             baud_tick_o
);
  localparam logic [WIDTH-1:0] MAX_CNT = '1;

  logic [WIDTH-1:0] cnt_q, rld_q, cnt_d, rld_d;
  logic             wrap;
  logic             baud_q;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    wrap  = 1'b0;
    if (step_i) begin
      unique case (mode_i)
        MODE_RELOAD: begin
          if (down_i) begin
            if (cnt_q == rld_q) begin
              cnt_d = MAX_CNT;
              wrap  = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end else if (cnt_q == MAX_CNT) begin
            cnt_d = rld_q;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        MODE_CAPTURE: begin
          cnt_d = cnt_q + 1'b1;
          wrap  = (cnt_q == MAX_CNT);
        end
        MODE_BAUD: begin
          if (cnt_q == MAX_CNT) begin
            cnt_d = rld_q;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
    if (trig_fire_i) begin
      if (mode_i == MODE_RELOAD) begin
        cnt_d = rld_q;
        wrap  = 1'b0;
      end else if (mode_i == MODE_CAPTURE) begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        rld_d = cnt_q;
      end
    end
    if (wr_cnt_i) begin
      cnt_d = wdata_i;
      wrap  = 1'b0;
    end
    if (wr_rld_i) rld_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      baud_q <= wrap & (mode_i == MODE_BAUD);
    end
  end

  assign cnt_o       = cnt_q;
  assign rld_o       = rld_q;
  assign ovf_set_o   = wrap & (mode_i != MODE_BAUD);
  assign baud_tick_o = baud_q;

  // R2
  up_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mode_i == MODE_RELOAD && !down_i && cnt_q == MAX_CNT &&
     !trig_fire_i && !wr_cnt_i) |=> cnt_q == $past(rld_q));
  // R3
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mode_i == MODE_RELOAD && down_i && cnt_q == rld_q &&
     !trig_fire_i && !wr_cnt_i) |=> cnt_q == MAX_CNT);
  // R5
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fire_i && mode_i == MODE_CAPTURE && !wr_rld_i) |=> rld_q == $past(cnt_q));
  // R6
  baud_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_q |-> $past(mode_i == MODE_BAUD && step_i));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !trig_fire_i && !wr_cnt_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_set_i,
  input  logic       ext_set_i,
  input  logic       flag_we_i,
  input  logic [1:0] flag_wdata_i,
  output logic       ovf_o,
  output logic       ext_o
);
  logic [1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 2'b00;
    end else if (flag_we_i) begin
      flags_q <= flag_wdata_i;
    end else begin
      if (ovf_set_i) flags_q[FLAG_OVF] <= 1'b1;
      if (ext_set_i) flags_q[FLAG_EXT] <= 1'b1;
    end
  end

  assign ovf_o = flags_q[FLAG_OVF];
  assign ext_o = flags_q[FLAG_EXT];

  // R9
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> flags_q == $past(flag_wdata_i));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we_i && ovf_o) |=> ovf_o);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             half_tick_i,
  input  logic             evt_i,
  input  logic             trig_i,
  input  logic             run_i,
  input  logic             evt_src_i,
  input  logic             trig_en_i,
  input  logic             down_i,
  input  logic             cap_mode_i,
  input  logic             tx_clk_sel_i,
  input  logic             rx_clk_sel_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  input  logic             rd_sel_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             flag_we_i,
  input  logic [1:0]       flag_wdata_i,
  output logic             ovf_flag_o,
  output logic             ext_flag_o,
  output logic             baud_tick_o
);
  tmr_mode_e        mode;
  logic             evt_fall, trig_fire, step, ovf_set;
  logic [WIDTH-1:0] cnt, rld;

  always_comb begin
    if (tx_clk_sel_i || rx_clk_sel_i) mode = MODE_BAUD;
    else if (cap_mode_i)              mode = MODE_CAPTURE;
    else                              mode = MODE_RELOAD;
  end

  tmr_edge_sampler u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .evt_i       (evt_i),
    .trig_i      (trig_i),
    .trig_en_i   (trig_en_i),
    .evt_fall_o  (evt_fall),
    .trig_fire_o (trig_fire)
  );

  always_comb begin
    if (!run_i)                 step = 1'b0;
    else if (mode == MODE_BAUD) step = half_tick_i;
    else if (evt_src_i)         step = evt_fall;
    else                        step = tick_i;
  end

  tmr_core #(.WIDTH(WIDTH)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .down_i      (down_i),
    .step_i      (step),
    .trig_fire_i (trig_fire),
    .wr_cnt_i    (reg_we_i && reg_sel_i == SEL_COUNT),
    .wr_rld_i    (reg_we_i && reg_sel_i == SEL_RELOAD),
    .wdata_i     (reg_wdata_i),
    .cnt_o       (cnt),
    .rld_o       (rld),
    .ovf_set_o   (ovf_set),
    .baud_tick_o (baud_tick_o)
  );

  tmr_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovf_set_i    (ovf_set),
    .ext_set_i    (trig_fire),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .ovf_o        (ovf_flag_o),
    .ext_o        (ext_flag_o)
  );

  assign rd_data_o = (rd_sel_i == SEL_RELOAD) ? rld : cnt;

  // R6
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BAUD && !flag_we_i && !trig_fire) |=> $stable(ovf_flag_o));
endmodule

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        down;
    logic [15:0] rld;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 16'h1000, 16'hFFFD, 8'd5, 16'h1002, 1'b1},
    '{2'd0, 1'b0, 16'h1000, 16'h0010, 8'd3, 16'h0013, 1'b0},
    '{2'd0, 1'b1, 16'h0100, 16'h0103, 8'd3, 16'h0100, 1'b0},
    '{2'd0, 1'b1, 16'h0100, 16'h0101, 8'd3, 16'hFFFE, 1'b1},
    '{2'd1, 1'b0, 16'h0000, 16'hFFFE, 8'd3, 16'h0001, 1'b1},
    '{2'd2, 1'b0, 16'hFFF0, 16'hFFFE, 8'd4, 16'hFFF2, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, half = 0, evt = 0, trig = 0, run = 0, evt_src = 0, trig_en = 0;
  logic down = 0, cap = 0, txs = 0, rxs = 0, reg_we = 0, reg_sel = 0, rd_sel = 0;
  logic [15:0] wdata = '0;
  logic flag_we = 0;
  logic [1:0] flag_wd = '0;
  logic [15:0] rd_data;
  logic ovf, ext, baud;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .half_tick_i(half), .evt_i(evt),
    .trig_i(trig), .run_i(run), .evt_src_i(evt_src), .trig_en_i(trig_en),
    .down_i(down), .cap_mode_i(cap), .tx_clk_sel_i(txs), .rx_clk_sel_i(rxs),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(wdata),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .flag_we_i(flag_we),
    .flag_wdata_i(flag_wd), .ovf_flag_o(ovf), .ext_flag_o(ext), .baud_tick_o(baud)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic sel, output logic [15:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic write_flags(input logic [1:0] d);
    @(negedge clk); flag_we = 1; flag_wd = d;
    @(negedge clk); flag_we = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic pulse_half();
    @(negedge clk); half = 1;
    @(negedge clk); half = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    read_reg(1'b0, v); check("R1 counter", v, 16'h0);
    read_reg(1'b1, v); check("R1 reload (R10 read)", v, 16'h0);
    check("R1 flags", {14'h0, ext, ovf}, 16'h0);
    check("R1 baud", {15'h0, baud}, 16'h0);

    // Vector table: R2, R3, R5, R6
    foreach (VECS[i]) begin
      run = 0; trig_en = 0; evt_src = 0;
      down = VECS[i].down;
      cap = (VECS[i].mode == 2'd1);
      txs = (VECS[i].mode == 2'd2);
      rxs = 0;
      write_flags(2'b00);
      write_reg(1'b1, VECS[i].rld);
      write_reg(1'b0, VECS[i].start);
      run = 1;
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        if (VECS[i].mode == 2'd2) pulse_half(); else pulse_tick();
      end
      read_reg(1'b0, v);
      check($sformatf("R2/R3/R5/R6 vector %0d count", i), v, VECS[i].exp_cnt);
      check($sformatf("R2/R3/R5/R6 vector %0d ovf", i), {15'h0, ovf}, {15'h0, VECS[i].exp_ovf});
    end
    txs = 0; cap = 0; down = 0;

    // R4 trigger edge reloads, wins over step
    write_flags(2'b00);
    write_reg(1'b1, 16'h4000);
    write_reg(1'b0, 16'h0005);
    run = 1; trig_en = 1;
    trig = 1; pulse_tick();
    trig = 0; pulse_tick();
    read_reg(1'b0, v); check("R4 reload on edge", v, 16'h4000);
    check("R4 ext flag set, no ovf", {14'h0, ext, ovf}, 16'h2);

    // R8 unqualified edge ignored
    write_flags(2'b00);
    write_reg(1'b0, 16'h0020);
    run = 0; trig_en = 0;
    trig = 1; pulse_tick();
    trig = 0; pulse_tick();
    read_reg(1'b0, v); check("R8 disabled edge count", v, 16'h0020);
    check("R8 disabled edge flag", {15'h0, ext}, 16'h0);
    // R8 level change between ticks not seen
    trig_en = 1;
    trig = 1; pulse_tick();
    trig = 0; repeat (3) @(negedge clk);
    trig = 1; pulse_tick();
    read_reg(1'b0, v); check("R8 between-tick low ignored", v, 16'h0020);
    check("R8 between-tick flag", {15'h0, ext}, 16'h0);
    trig = 0; pulse_tick();
    read_reg(1'b0, v); check("R8 sampled edge acts", v, 16'h4000);

    // R5 capture copies count, count unchanged
    write_flags(2'b00);
    cap = 1; run = 0; trig_en = 1;
    write_reg(1'b0, 16'h1234);
    write_reg(1'b1, 16'h0000);
    trig = 1; pulse_tick();
    trig = 0; pulse_tick();
    read_reg(1'b1, v); check("R5 captured value", v, 16'h1234);
    read_reg(1'b0, v); check("R5 count unchanged", v, 16'h1234);
    check("R5 ext flag", {15'h0, ext}, 16'h1);

    // R6 baud via receive select overrides capture
    write_flags(2'b00);
    trig_en = 0; rxs = 1; run = 1;
    write_reg(1'b1, 16'hFFF0);
    write_reg(1'b0, 16'hFFFF);
    pulse_half();
    check("R6 baud strobe", {15'h0, baud}, 16'h1);
    read_reg(1'b0, v); check("R6 reload on wrap", v, 16'hFFF0);
    check("R6 no ovf", {15'h0, ovf}, 16'h0);
    @(negedge clk);
    check("R6 strobe one cycle", {15'h0, baud}, 16'h0);
    pulse_tick();
    read_reg(1'b0, v); check("R6 tick ignored in baud", v, 16'hFFF0);
    rxs = 0; cap = 0;

    // R9 flag write wins over overflow
    write_flags(2'b00);
    write_reg(1'b1, 16'h0000);
    write_reg(1'b0, 16'hFFFF);
    @(negedge clk); tick = 1; flag_we = 1; flag_wd = 2'b00;
    @(negedge clk); tick = 0; flag_we = 0;
    check("R9 flag write priority", {15'h0, ovf}, 16'h0);
    read_reg(1'b0, v); check("R9 step still taken", v, 16'h0000);
    write_flags(2'b10);
    check("R9 flag write value", {14'h0, ext, ovf}, 16'h2);
    // R9 counter write wins over step
    write_reg(1'b0, 16'h0050);
    @(negedge clk); tick = 1; reg_we = 1; reg_sel = 0; wdata = 16'h0700;
    @(negedge clk); tick = 0; reg_we = 0;
    read_reg(1'b0, v); check("R9 count write priority", v, 16'h0700);

    // R7 event-pin counting
    write_reg(1'b0, 16'h0000);
    evt_src = 1; run = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); evt = 1;
      @(negedge clk); evt = 0;
    end
    @(negedge clk);
    read_reg(1'b0, v); check("R7 event count", v, 16'h0003);
    pulse_tick();
    read_reg(1'b0, v); check("R7 tick ignored with events", v, 16'h0003);
    run = 0;
    @(negedge clk); evt = 1;
    @(negedge clk); evt = 0;
    @(negedge clk);
    read_reg(1'b0, v); check("R7 run low holds", v, 16'h0003);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule